// File: doc/BRIEF.md
# I2C Write-Only Configuration Slave

This block is a receive-only I2C target that loads a small set of clock-synthesis control values: a 9-bit feedback divider value, a 2-bit output divider select, two spread-direction flags and a 6-bit spread amount. The SCL and SDA lines are oversampled on the system clock, which must run at least eight times faster than SCL. From the sampled lines the block detects START and STOP, shifts in bytes and pulls SDA low to acknowledge.

A valid transfer is a write to one of two 7-bit addresses, chosen by a strap pin. It carries four data bytes. The first is a placeholder and is thrown away. The other three fill a shadow copy of the control values. The visible outputs change only when the master ends the frame with STOP after all four data bytes have been acknowledged. Partial frames, foreign addresses and read requests leave the outputs alone. Bytes past the fourth are refused.

Top module: `i2c_cfg_slave`

## Requirements
- R1: With `addr_sel` = 0 the block answers address 7'b1101100, and with `addr_sel` = 1 it answers 7'b1101110. The address is followed by an R/W bit, and R/W = 0 means write. A matching write address is acknowledged.
- R2: A non-matching address, or a matching address with R/W = 1, is not acknowledged. The data bytes that follow are not acknowledged either, and the transfer changes no output.
- R3: To acknowledge, the block asserts `sda_oe` after the SCL falling edge that ends the eighth bit of a byte. It releases `sda_oe` after the next SCL falling edge. `sda_oe` never changes while SCL is high.
- R4: The first data byte after the address is a placeholder, and its value has no effect on any output.
- R5: In the second data byte, bits [7:6] give `n_sel` and bits [5:0] give `m_div[8:3]`.
- R6: In the third data byte, bits [2:0] give `m_div[2:0]`, and bits [7:3] have no effect.
- R7: In the fourth data byte, bit 7 gives `spread_up`, bit 6 gives `spread_down` and bits [5:0] give `spread_amt`.
- R8: The outputs keep their old values while a frame is in progress. They take the new values only after a STOP that follows four acknowledged data bytes.
- R9: After reset, `m_div` = 256, `n_sel` = 0, `spread_up` = 0, `spread_down` = 0 and `spread_amt` = 0.
- R10: Data bytes beyond the fourth are not acknowledged, and their contents never reach the outputs. The four bytes before them are still committed at STOP.
- R11: A frame that ends with STOP before four data bytes have been acknowledged commits nothing.
- R12: A repeated START abandons the frame in progress, and address reception begins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Strap that selects between the two target addresses |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | High to pull SDA low (acknowledge) |
| m_div | output | 9 | Committed feedback divider value |
| n_sel | output | 2 | Committed output divider select |
| spread_up | output | 1 | Committed upward spread flag |
| spread_down | output | 1 | Committed downward spread flag |
| spread_amt | output | 6 | Committed spread amount |

## Verification
The hardest cases to reach are those where acknowledgement and commit come apart. A frame whose fifth byte is refused must still commit its first four. A frame cut off by a repeated START must leave no trace, even though some of its bytes have already been written into the shadow register. To reach these cases, a bit-level master in the bench builds frames of any byte count, with or without STOP. It samples the acknowledge bit of every byte on the open-drain line. It also checks that the outputs are still unchanged just before STOP, so that commit timing is seen separately from the data values.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

   localparam int M_W  = 9;
   localparam int N_W  = 2;
   localparam int SS_W = 6;

   localparam logic [M_W-1:0] DEF_M = 9'd256;

   typedef enum logic [1:0] {
      LK_IDLE = 2'd0,
      LK_RECV = 2'd1,
      LK_ACK  = 2'd2,
      LK_SKIP = 2'd3
   } link_st_e;

   typedef struct packed {
      logic [M_W-1:0]  m;
      logic [N_W-1:0]  n;
      logic            up;
      logic            dn;
      logic [SS_W-1:0] ss;
   } cfg_t;

endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_rise,
   output logic scl_fall,
   output logic sda_lvl,
   output logic start_det,
   output logic stop_det
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfgs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_sh, sda_sh;
   logic              scl_q, sda_q;
   logic              scl_s, sda_s;

   assign scl_s = scl_sh[STAGES-1];
   assign sda_s = sda_sh[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_in};
         sda_sh <= {sda_sh[STAGES-2:0], sda_in};
         scl_q  <= scl_s;
         sda_q  <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign sda_lvl   = sda_s;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/cfgs_link.sv
module cfgs_link
   import cfgs_pkg::*;
#(
   parameter logic [6:0] ADDR_BASE   = 7'b1101100,
   parameter int          SEL_BIT     = 1,
   parameter int          FRAME_BYTES = 4,
   localparam int         CNT_W       = $clog2(FRAME_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_sel,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             sda_lvl,
   input  logic             start_det,
   input  logic             stop_det,
   output logic             sda_oe,
   output logic             wr_en,
   output logic [CNT_W-1:0] wr_idx,
   output logic [7:0]       wr_byte,
   output logic             commit
);

   generate
      if (SEL_BIT < 0 || SEL_BIT > 6) begin : g_bad_sel
         $error("cfgs_link: SEL_BIT must address one of the 7 address bits");
      end
      if (FRAME_BYTES < 1) begin : g_bad_frame
         $error("cfgs_link: FRAME_BYTES must be positive");
      end
   endgenerate

   link_st_e         st;
   logic [7:0]       sh;
   logic [3:0]       bit_cnt;
   logic [CNT_W-1:0] byte_cnt;
   logic             is_addr;
   logic [6:0]       my_addr;
   logic             addr_hit;

   always_comb begin
      my_addr          = ADDR_BASE;
      my_addr[SEL_BIT] = addr_sel;
   end

   assign addr_hit = (sh == {my_addr, 1'b0});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= LK_IDLE;
         sh       <= '0;
         bit_cnt  <= '0;
         byte_cnt <= '0;
         is_addr  <= 1'b0;
         sda_oe   <= 1'b0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_byte  <= '0;
         commit   <= 1'b0;
      end else begin
         wr_en  <= 1'b0;
         commit <= 1'b0;
         if (start_det) begin
            st       <= LK_RECV;
            is_addr  <= 1'b1;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            sda_oe   <= 1'b0;
         end else if (stop_det) begin
            st       <= LK_IDLE;
            sda_oe   <= 1'b0;
            commit   <= (byte_cnt == CNT_W'(FRAME_BYTES));
            byte_cnt <= '0;
         end else begin
            unique case (st)
               LK_RECV: begin
                  if (scl_rise && bit_cnt < 4'd8) begin
                     sh      <= {sh[6:0], sda_lvl};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     bit_cnt <= '0;
                     if (is_addr) begin
                        is_addr <= 1'b0;
                        if (addr_hit) begin
                           st     <= LK_ACK;
                           sda_oe <= 1'b1;
                        end else begin
                           st <= LK_SKIP;
                        end
                     end else if (byte_cnt < CNT_W'(FRAME_BYTES)) begin
                        st       <= LK_ACK;
                        sda_oe   <= 1'b1;
                        wr_en    <= 1'b1;
                        wr_idx   <= byte_cnt;
                        wr_byte  <= sh;
                        byte_cnt <= byte_cnt + 1'b1;
                     end else begin
                        st <= LK_SKIP;
                     end
                  end
               end
               LK_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     st     <= LK_RECV;
                  end
               end
               default: begin
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/cfgs_regs.sv
module cfgs_regs
   import cfgs_pkg::*;
#(
   parameter int  FRAME_BYTES = 4,
   parameter int  SKIP_BYTES  = 1,
   localparam int CNT_W       = $clog2(FRAME_BYTES + 1),
   localparam int CTRL_BYTES  = FRAME_BYTES - SKIP_BYTES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_idx,
   input  logic [7:0]       wr_byte,
   input  logic             commit,
   output cfg_t             cfg
);

   generate
      if (CTRL_BYTES != 3) begin : g_bad_layout
         $error("cfgs_regs: the control layout needs exactly three bytes after the skipped ones");
      end
   endgenerate

   localparam logic [CTRL_BYTES-1:0][7:0] SHAD_RST =
      {8'h00, {5'b0, DEF_M[2:0]}, {2'b00, DEF_M[8:3]}};

   logic [CTRL_BYTES-1:0][7:0] shad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shad <= SHAD_RST;
      end else if (wr_en) begin
         for (int g = 0; g < CTRL_BYTES; g++) begin
            if (wr_idx == CNT_W'(g + SKIP_BYTES)) shad[g] <= wr_byte;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.m  <= DEF_M;
         cfg.n  <= '0;
         cfg.up <= 1'b0;
         cfg.dn <= 1'b0;
         cfg.ss <= '0;
      end else if (commit) begin
         cfg.n  <= shad[0][7:6];
         cfg.m  <= {shad[0][5:0], shad[1][2:0]};
         cfg.up <= shad[2][7];
         cfg.dn <= shad[2][6];
         cfg.ss <= shad[2][5:0];
      end
   end

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
   import cfgs_pkg::*;
#(
   parameter logic [6:0] ADDR_BASE   = 7'b1101100,
   parameter int          SEL_BIT     = 1,
   parameter int          SYNC_STAGES = 2,
   parameter int          FRAME_BYTES = 4,
   parameter int          SKIP_BYTES  = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            addr_sel,
   input  logic            scl_in,
   input  logic            sda_in,
   output logic            sda_oe,
   output logic [M_W-1:0]  m_div,
   output logic [N_W-1:0]  n_sel,
   output logic            spread_up,
   output logic            spread_down,
   output logic [SS_W-1:0] spread_amt
);

   localparam int CNT_W = $clog2(FRAME_BYTES + 1);

   logic             scl_rise_w, scl_fall_w, sda_lvl_w, start_w, stop_w;
   logic             wr_en_w, commit_w;
   logic [CNT_W-1:0] wr_idx_w;
   logic [7:0]       wr_byte_w;
   cfg_t             cfg_w;

   cfgs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .scl_rise  (scl_rise_w),
      .scl_fall  (scl_fall_w),
      .sda_lvl   (sda_lvl_w),
      .start_det (start_w),
      .stop_det  (stop_w)
   );

   cfgs_link #(
      .ADDR_BASE   (ADDR_BASE),
      .SEL_BIT     (SEL_BIT),
      .FRAME_BYTES (FRAME_BYTES)
   ) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_sel  (addr_sel),
      .scl_rise  (scl_rise_w),
      .scl_fall  (scl_fall_w),
      .sda_lvl   (sda_lvl_w),
      .start_det (start_w),
      .stop_det  (stop_w),
      .sda_oe    (sda_oe),
      .wr_en     (wr_en_w),
      .wr_idx    (wr_idx_w),
      .wr_byte   (wr_byte_w),
      .commit    (commit_w)
   );

   cfgs_regs #(
      .FRAME_BYTES (FRAME_BYTES),
      .SKIP_BYTES  (SKIP_BYTES)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_w),
      .wr_idx  (wr_idx_w),
      .wr_byte (wr_byte_w),
      .commit  (commit_w),
      .cfg     (cfg_w)
   );

   assign m_div       = cfg_w.m;
   assign n_sel       = cfg_w.n;
   assign spread_up   = cfg_w.up;
   assign spread_down = cfg_w.dn;
   assign spread_amt  = cfg_w.ss;

endmodule

// File: rtl/cfgs_chk.sv
module cfgs_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_in,
   input logic       sda_oe,
   input logic       commit,
   input logic [8:0] m_div,
   input logic [1:0] n_sel,
   input logic       spread_up,
   input logic       spread_down,
   input logic [5:0] spread_amt
);

   // R3
   oe_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_in && $past(scl_in)) |-> $stable(sda_oe));

   // R3
   oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> !scl_in);

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({m_div, n_sel, spread_up, spread_down, spread_amt}) |-> $past(commit));

   // R9
   reset_val_chk: assert property (@(posedge clk)
      !rst_n |=> (m_div == 9'd256 && n_sel == 2'd0 && !spread_up && !spread_down
                  && spread_amt == 6'd0));

endmodule

bind i2c_cfg_slave cfgs_chk u_cfgs_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_in      (scl_in),
   .sda_oe      (sda_oe),
   .commit      (commit_w),
   .m_div       (m_div),
   .n_sel       (n_sel),
   .spread_up   (spread_up),
   .spread_down (spread_down),
   .spread_amt  (spread_amt)
);

// File: tb/i2c_cfg_slave_test.sv
module i2c_cfg_slave_test;

   typedef struct {
      string       tag;
      logic [18:0] val;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic addr_sel = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic sda_line;
   logic sda_oe;
   logic [8:0] m_div;
   logic [1:0] n_sel;
   logic spread_up, spread_down;
   logic [5:0] spread_amt;

   assign sda_line = sda_m & ~sda_oe;

   i2c_cfg_slave uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_sel    (addr_sel),
      .scl_in      (scl),
      .sda_in      (sda_line),
      .sda_oe      (sda_oe),
      .m_div       (m_div),
      .n_sel       (n_sel),
      .spread_up   (spread_up),
      .spread_down (spread_down),
      .spread_amt  (spread_amt)
   );

   always #10 clk = ~clk;

   int          n_chk = 0;
   int          n_bad = 0;
   bit          ended = 1'b0;
   exp_t        expq[$];
   logic [18:0] model;
   logic [7:0]  bytes[8];
   bit          pending;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [18:0] decode(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
      return {b0[5:0], b1[2:0], b0[7:6], b2[7], b2[6], b2[5:0]};
   endfunction

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // monitor: compares outputs against each queued expectation
   initial begin
      forever begin
         exp_t e;
         wait (expq.size() > 0);
         e = expq.pop_front();
         check(e.tag, {13'b0, m_div, n_sel, spread_up, spread_down, spread_amt},
               {13'b0, e.val});
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   task automatic q_wait(int n);
      repeat (n * 10) @(negedge clk);
   endtask

   task automatic push(string tag);
      exp_t e;
      q_wait(2);
      e.tag = tag;
      e.val = model;
      expq.push_back(e);
      q_wait(1);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; q_wait(1);
      scl = 1'b1;   q_wait(1);
      sda_m = 1'b0; q_wait(1);
      scl = 1'b0;   q_wait(1);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; q_wait(1);
      scl = 1'b1;   q_wait(1);
      sda_m = 1'b1; q_wait(2);
   endtask

   task automatic put_bit(logic b);
      sda_m = b;  q_wait(1);
      scl = 1'b1; q_wait(2);
      scl = 1'b0; q_wait(1);
   endtask

   task automatic put_byte(logic [7:0] b, string tag, logic ack_exp);
      logic ack_a, ack_b;
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      sda_m = 1'b1; q_wait(1);
      scl = 1'b1;
      repeat (2) @(negedge clk);
      ack_a = ~sda_line;
      q_wait(1);
      ack_b = ~sda_line;
      scl = 1'b0; q_wait(1);
      check({tag, " R3 ack"}, {30'b0, ack_a, ack_b}, {30'b0, ack_exp, ack_exp});
   endtask

   task automatic frame(string tag, logic [6:0] a, logic rw, int nb, bit fin);
      bit match;
      match = (a == (addr_sel ? 7'b1101110 : 7'b1101100)) && !rw;
      bus_start();
      put_byte({a, rw}, tag, match);
      for (int k = 0; k < nb; k++) put_byte(bytes[k], tag, match && (k < 4));
      pending = match && (nb >= 4);
      if (fin) begin
         bus_stop();
         if (pending) model = decode(bytes[1], bytes[2], bytes[3]);
         pending = 1'b0;
         push(tag);
      end
   endtask

   task automatic close(string tag);
      bus_stop();
      if (pending) model = decode(bytes[1], bytes[2], bytes[3]);
      pending = 1'b0;
      push(tag);
   endtask

   initial begin
      model = {9'd256, 2'd0, 1'b0, 1'b0, 6'd0};
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      push("R9 reset defaults");

      // R5 R6 R7: full frame; outputs held before STOP (R8)
      bytes[0] = 8'hA5; bytes[1] = 8'hB3; bytes[2] = 8'hFD; bytes[3] = 8'hC7;
      frame("R1 sel0 write", 7'b1101100, 1'b0, 4, 1'b0);
      push("R8 held before STOP");
      close("R5 R6 R7 commit at STOP");

      // R2 wrong address
      bytes[0] = 8'h00; bytes[1] = 8'h41; bytes[2] = 8'h03; bytes[3] = 8'h11;
      frame("R2 foreign address", 7'b1101110, 1'b0, 4, 1'b1);

      // R1 alternate address
      addr_sel = 1'b1;
      q_wait(1);
      bytes[0] = 8'h00; bytes[1] = 8'h4A; bytes[2] = 8'h02; bytes[3] = 8'h65;
      frame("R1 sel1 write", 7'b1101110, 1'b0, 4, 1'b1);

      // R2 read request refused
      frame("R2 read request", 7'b1101110, 1'b1, 0, 1'b1);

      // R10 extra bytes refused, first four kept
      bytes[0] = 8'h11; bytes[1] = 8'h3F; bytes[2] = 8'h07; bytes[3] = 8'h9A;
      bytes[4] = 8'hFF; bytes[5] = 8'h00;
      frame("R10 extra bytes", 7'b1101110, 1'b0, 6, 1'b1);

      // R11 short frame
      bytes[0] = 8'hFF; bytes[1] = 8'hC0; bytes[2] = 8'h07;
      frame("R11 short frame", 7'b1101110, 1'b0, 3, 1'b1);

      // R12 repeated START mid-frame
      bytes[0] = 8'h55; bytes[1] = 8'hFF;
      frame("R12 cut frame", 7'b1101110, 1'b0, 2, 1'b0);
      bytes[0] = 8'h00; bytes[1] = 8'h20; bytes[2] = 8'h00; bytes[3] = 8'h00;
      frame("R12 restarted frame", 7'b1101110, 1'b0, 4, 1'b1);

      // R4 placeholder byte value has no effect
      bytes[0] = 8'hC3; bytes[1] = 8'h4A; bytes[2] = 8'h02; bytes[3] = 8'h65;
      frame("R4 placeholder C3", 7'b1101110, 1'b0, 4, 1'b1);
      bytes[0] = 8'h3C;
      frame("R4 placeholder 3C", 7'b1101110, 1'b0, 4, 1'b1);

      wait (expq.size() == 0);
      q_wait(1);
      finish_run();
   end

endmodule